// File: doc/BRIEF.md
# Serial Link Flow Gate

This unit sits beside a serial transmitter, receiver and receive queue and decides when frames may be sent or taken in. Software reaches one 32-bit control word through a synchronous write port and a read port with one cycle of latency. The word selects how the ready/pause output toward the far end is driven, whether the incoming clear-to-send line gates transmission, whether the transmitter and receiver may run, and whether the serial output is forced low to send a break.

The pause output is driven either straight from a software bit or, in hardware mode, from a comparison of the receive queue occupancy against a 4-bit fill threshold. Permission to start a new transmit frame is granted only while the transmitter is idle, so a frame that has begun always finishes. This holds even if transmission is disabled or clear-to-send drops partway through the frame.

Top module: `serial_flow_unit`

## Requirements
- R1: After reset the control word reads 0x0000_0182: receive disable (bit 8) = 1, transmit disable (bit 7) = 1, fill threshold (bits 4:1) = 1, all other fields 0.
- R2: Only bits 12 (hardware pause enable), 11 (clear-to-send gating enable), 9 (software pause level), 8, 7, 4:1 and 0 (break) can be stored. Writing all ones reads back 0x0000_1B9F.
- R3: A read at the control address returns the word on `rdData` in the cycle after `regRd`. A read at any other address returns 0, and a write to any other address leaves the word unchanged.
- R4: With bit 12 clear, `rtsOut` equals bit 9 one cycle after the write.
- R5: With bit 12 set and a nonzero threshold, `rtsOut` is 1 one cycle after `rxCount` is at or above the threshold, and 0 one cycle after it is below. Bit 9 has no effect in this mode.
- R6: With bit 12 set and a threshold of 0, `rtsOut` stays 0 at any occupancy.
- R7: With bit 11 clear, `ctsN` has no effect on `txStartOk`.
- R8: With bit 11 set, `ctsN` (active low) passes through two flops: `txStartOk` follows a change of `ctsN` on the second clock edge after it, and is 0 while the synchronized value is 1.
- R9: `txStartOk` is 1 only while `txBusy` is 0, bit 7 is 0 and the clear-to-send condition is met. A frame in progress is never cut short.
- R10: `rxAccept` is the inverse of bit 8. Setting bit 8 never drives `rtsOut` high by itself.
- R11: While bit 0 is 1, `txdOut` is 0 whatever `txdRaw` is. Otherwise `txdOut` equals `txdRaw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register address |
| regWdata | input | 32 | Write data |
| rdData | output | 32 | Read data, one cycle after `regRd` |
| rxCount | input | CNT_W | Receive queue occupancy |
| ctsN | input | 1 | Clear-to-send from the peer, low = peer ready |
| txBusy | input | 1 | Transmitter is mid-frame |
| txdRaw | input | 1 | Serial output from the shifter |
| txdOut | output | 1 | Serial output to the pin |
| rtsOut | output | 1 | Pause request to the peer, high = pause |
| txStartOk | output | 1 | A new transmit frame may start |
| rxAccept | output | 1 | The receiver may accept a start bit |

## Verification
The pause output and the receive enable can change in the same cycle. This happens when software sets receive disable on the same clock edge at which the queue occupancy reaches the hardware threshold. The bench provokes this by driving the write and the new `rxCount` on the same falling edge. It then checks that `rtsOut` rises because of occupancy alone while `rxAccept` drops, so neither update masks the other.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int WORD_W = 32;
  localparam int TRIG_W = 4;

  typedef struct packed {
    logic              rtsHwEn;
    logic              ctsEn;
    logic              swRts;
    logic              rxDis;
    logic              txDis;
    logic [TRIG_W-1:0] rtsTrig;
    logic              brk;
  } flow_ctrl_t;

  localparam flow_ctrl_t CTRL_RESET = '{
    rtsHwEn: 1'b0, ctsEn: 1'b0, swRts: 1'b0, rxDis: 1'b1,
    txDis: 1'b1, rtsTrig: 4'd1, brk: 1'b0};

  function automatic logic [WORD_W-1:0] packCtrl(input flow_ctrl_t c);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[12]    = c.rtsHwEn;
    w[11]    = c.ctsEn;
    w[9]     = c.swRts;
    w[8]     = c.rxDis;
    w[7]     = c.txDis;
    w[4:1]   = c.rtsTrig;
    w[0]     = c.brk;
    return w;
  endfunction

  function automatic flow_ctrl_t unpackCtrl(input logic [WORD_W-1:0] w);
    flow_ctrl_t c;
    c.rtsHwEn = w[12];
    c.ctsEn   = w[11];
    c.swRts   = w[9];
    c.rxDis   = w[8];
    c.txDis   = w[7];
    c.rtsTrig = w[4:1];
    c.brk     = w[0];
    return c;
  endfunction
endpackage

// File: rtl/flow_regs.sv
module flow_regs
  import flow_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic                regRd,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [WORD_W-1:0]   regWdata,
  output logic [WORD_W-1:0]   rdData,
  output flow_ctrl_t          ctrl
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CTRL_ADDR);

  logic addrHit;
  assign addrHit = (regAddr == HIT_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrl <= CTRL_RESET;
    end else if (regWe && addrHit) begin
      ctrl <= unpackCtrl(regWdata);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (regRd && addrHit) begin
      rdData <= packCtrl(ctrl);
    end else begin
      rdData <= '0;
    end
  end

  p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[31:13] == '0) && (rdData[10] == 1'b0) && (rdData[6:5] == 2'b00));

  p_miss_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !addrHit) |=> $stable(ctrl));
endmodule

// File: rtl/flow_path.sv
module flow_path
  import flow_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  flow_ctrl_t       ctrl,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             ctsN,
  input  logic             txBusy,
  input  logic             txdRaw,
  output logic             txdOut,
  output logic             rtsOut,
  output logic             txStartOk,
  output logic             rxAccept
);
  localparam int SYNC_DEPTH = 2;

  logic [SYNC_DEPTH-1:0] ctsPipe;
  logic                  ctsSynced;
  logic                  peerReady;
  logic                  fillHit;
  logic                  rtsNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctsPipe <= '1;
    else       ctsPipe <= {ctsPipe[SYNC_DEPTH-2:0], ctsN};
  end
  assign ctsSynced = ctsPipe[SYNC_DEPTH-1];
  assign peerReady = !ctrl.ctsEn || !ctsSynced;

  assign fillHit = (ctrl.rtsTrig != '0) && (rxCount >= CNT_W'(ctrl.rtsTrig));
  assign rtsNext = ctrl.rtsHwEn ? fillHit : ctrl.swRts;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rtsOut <= 1'b0;
    else       rtsOut <= rtsNext;
  end

  assign txStartOk = !txBusy && !ctrl.txDis && peerReady;
  assign rxAccept  = !ctrl.rxDis;
  assign txdOut    = ctrl.brk ? 1'b0 : txdRaw;

  p_start_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    txStartOk |-> !txBusy);

  p_sw_rts_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(!ctrl.rtsHwEn) |-> (rtsOut == $past(ctrl.swRts)));

  p_zero_trig_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.rtsHwEn && (ctrl.rtsTrig == '0)) |-> !rtsOut);

  p_cts_block_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.ctsEn && ctsSynced) |-> !txStartOk);

  p_break_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.brk |-> !txdOut);
endmodule

// File: rtl/serial_flow_unit.sv
module serial_flow_unit
  import flow_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int CNT_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       rdData,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              ctsN,
  input  logic              txBusy,
  input  logic              txdRaw,
  output logic              txdOut,
  output logic              rtsOut,
  output logic              txStartOk,
  output logic              rxAccept
);
  flow_ctrl_t ctrl;

  flow_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) uRegs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .rdData(rdData), .ctrl(ctrl)
  );

  flow_path #(.CNT_W(CNT_W)) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .rxCount(rxCount), .ctsN(ctsN),
    .txBusy(txBusy), .txdRaw(txdRaw), .txdOut(txdOut), .rtsOut(rtsOut),
    .txStartOk(txStartOk), .rxAccept(rxAccept)
  );

  p_rx_pause_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!ctrl.rtsHwEn) && $past(!ctrl.swRts)) |-> !rtsOut);
endmodule

// File: tb/serial_flow_unit_test.sv
module serial_flow_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic        regRd = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] rdData;
  logic [4:0]  rxCount = '0;
  logic        ctsN = 1'b1;
  logic        txBusy = 1'b0;
  logic        txdRaw = 1'b1;
  logic        txdOut, rtsOut, txStartOk, rxAccept;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  serial_flow_unit uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .rdData(rdData), .rxCount(rxCount), .ctsN(ctsN),
    .txBusy(txBusy), .txdRaw(txdRaw), .txdOut(txdOut), .rtsOut(rtsOut),
    .txStartOk(txStartOk), .rxAccept(rxAccept)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regAddr = '0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    d = rdData;
    regRd = 1'b0; regAddr = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R10 reset rxAccept", 32'(rxAccept), 32'd0);
    chk("R9 reset txStartOk", 32'(txStartOk), 32'd0);
    chk("R4 reset rtsOut", 32'(rtsOut), 32'd0);
    rdReg(4'd0, v);
    chk("R1 reset word", v, 32'h0000_0182);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wrReg(4'd0, 32'hFFFF_FFFF);
    rdReg(4'd0, v);
    chk("R2 reserved masked", v, 32'h0000_1B9F);
    rdReg(4'd3, v);
    chk("R3 other addr reads zero", v, 32'd0);
    wrReg(4'd5, 32'h0000_0000);
    rdReg(4'd0, v);
    chk("R3 other addr write ignored", v, 32'h0000_1B9F);
    @(negedge clk); regRd = 1'b1; regAddr = 4'd0;
    @(negedge clk); regRd = 1'b0;
    @(negedge clk);
    chk("R3 read data lasts one cycle", rdData, 32'd0);
    wrReg(4'd0, 32'h0);
  endtask

  task automatic t_swRts();
    wrReg(4'd0, 32'h200); settle(1);
    chk("R4 sw rts high", 32'(rtsOut), 32'd1);
    wrReg(4'd0, 32'h0); settle(1);
    chk("R4 sw rts low", 32'(rtsOut), 32'd0);
  endtask

  task automatic t_hwRts();
    wrReg(4'd0, 32'h1206);
    @(negedge clk); rxCount = 5'd2;
    settle(1);
    chk("R5 below level, sw bit ignored", 32'(rtsOut), 32'd0);
    rxCount = 5'd3;
    chk("R5 not yet registered", 32'(rtsOut), 32'd0);
    settle(1);
    chk("R5 at level", 32'(rtsOut), 32'd1);
    rxCount = 5'd15; settle(1);
    chk("R5 above level", 32'(rtsOut), 32'd1);
    rxCount = 5'd2; settle(1);
    chk("R5 drops below level", 32'(rtsOut), 32'd0);
    wrReg(4'd0, 32'h1000);
    rxCount = 5'd31; settle(2);
    chk("R6 zero level never asserts", 32'(rtsOut), 32'd0);
    rxCount = 5'd0;
    wrReg(4'd0, 32'h0); settle(1);
  endtask

  task automatic t_cts();
    txBusy = 1'b0;
    wrReg(4'd0, 32'h0);
    ctsN = 1'b1; settle(3);
    chk("R7 cts ignored when off", 32'(txStartOk), 32'd1);
    wrReg(4'd0, 32'h800);
    chk("R8 peer not ready blocks", 32'(txStartOk), 32'd0);
    ctsN = 1'b0; settle(1);
    chk("R8 one flop not enough", 32'(txStartOk), 32'd0);
    settle(1);
    chk("R8 ready after two flops", 32'(txStartOk), 32'd1);
    txBusy = 1'b1; #1;
    chk("R9 busy blocks start", 32'(txStartOk), 32'd0);
    ctsN = 1'b1; settle(3);
    txBusy = 1'b0; #1;
    chk("R8 blocked after frame ends", 32'(txStartOk), 32'd0);
    ctsN = 1'b0;
    wrReg(4'd0, 32'h0); settle(2);
  endtask

  task automatic t_txDis();
    txBusy = 1'b0;
    wrReg(4'd0, 32'h80);
    chk("R9 tx disabled", 32'(txStartOk), 32'd0);
    wrReg(4'd0, 32'h0);
    chk("R9 tx resumes", 32'(txStartOk), 32'd1);
  endtask

  task automatic t_rxDis();
    wrReg(4'd0, 32'h100); settle(1);
    chk("R10 rx disabled", 32'(rxAccept), 32'd0);
    chk("R10 rts unaffected", 32'(rtsOut), 32'd0);
    wrReg(4'd0, 32'h0);
    chk("R10 rx enabled", 32'(rxAccept), 32'd1);
  endtask

  task automatic t_break();
    txdRaw = 1'b1;
    wrReg(4'd0, 32'h1);
    chk("R11 break holds low", 32'(txdOut), 32'd0);
    txdRaw = 1'b0; #1; txdRaw = 1'b1; #1;
    chk("R11 break ignores raw", 32'(txdOut), 32'd0);
    wrReg(4'd0, 32'h0);
    chk("R11 normal restored", 32'(txdOut), 32'd1);
    txdRaw = 1'b0; #1;
    chk("R11 follows raw", 32'(txdOut), 32'd0);
    txdRaw = 1'b1;
  endtask

  task automatic t_collide();
    wrReg(4'd0, 32'h1004);
    rxCount = 5'd1; settle(1);
    chk("R5 below level before collision", 32'(rtsOut), 32'd0);
    @(negedge clk);
    rxCount = 5'd2; regWe = 1'b1; regAddr = 4'd0; regWdata = 32'h1104;
    @(negedge clk);
    regWe = 1'b0;
    chk("R5 level reached same edge", 32'(rtsOut), 32'd1);
    chk("R10 rx disabled same edge", 32'(rxAccept), 32'd0);
    rxCount = 5'd0; settle(1);
    chk("R10 disable does not hold rts", 32'(rtsOut), 32'd0);
  endtask

  initial begin
    fork
      begin
        settle(3);
        rstN = 1'b1;
        settle(1);
        t_reset();
        t_regs();
        t_swRts();
        t_hwRts();
        t_cts();
        t_txDis();
        t_rxDis();
        t_break();
        t_collide();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule